// File: doc/BRIEF.md
# Indexed Memory Window Decoder

This block holds the setup for five system memory windows that belong to one card socket. It also tells, for every bus address, which window the address falls into. Software sets the windows up through a small indexed port: it first writes an 8-bit index, then reads or writes the data byte at that index. Each window stores three things:

- a 12-bit first page,
- a 12-bit last page,
- a two-bit timing selector.

The pages cover address bits 23:12 of a 24-bit system address. A separate register turns each window on or off.

On every clock the decoder compares the page of the bus address with all windows at once. Both bounds of a window are inclusive. The decoder registers three results:

- a hit flag,
- the number of the winning window,
- which of two timing sets that window uses.

When windows overlap, the lowest-numbered enabled window wins. The timing selector is a legacy two-bit code in which only code 00 means set 0.

Top module: `memwin_decoder`

## Requirements
- R1: While reset is high, and until the next write, every register reads 00h. The decode outputs hit, win_num and timing_set are all 0.
- R2: An index write (idx_wr) loads wdata as the current index. A data write (data_wr) stores wdata into the register at that index. rdata shows the register at the current index, registered one cycle after the index or data changes. For window w the registers sit at these indexes:
  - 10h+8w: first page bits 7:0
  - 11h+8w: first page bits 11:8 in bits 3:0, with bits 7:4 reading 0
  - 12h+8w: last page bits 7:0
  - 13h+8w: the end-high register
- R3: In the end-high register, bits 3:0 hold last page bits 11:8. Bits 5:4 are scratch bits: they read back as written and have no effect on decoding. Bits 7:6 hold the timing selector.
- R4: The register at index 06h holds the window enables: bit w enables window w. Bits 7:5 read 0.
- R5: An enabled window w hits when first ≤ bus_addr[23:12] ≤ last, with both ends inclusive. The result appears on the outputs at the clock edge after the address is presented.
- R6: A disabled window never produces a hit.
- R7: A window whose first page is above its last page never matches any address.
- R8: When several enabled windows match, win_num reports the lowest-numbered one.
- R9: timing_set is 0 when the winner's selector is 00, and 1 for selectors 01, 10 and 11.
- R10: An index that is neither 06h nor one of the 20 window indexes reads 00h, and writes to it change no register. Examples are 00h, 08h, 14h and 38h.
- R11: When no window matches, hit, win_num and timing_set are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Load wdata as the current index |
| data_wr | input | 1 | Write wdata to the register at the current index |
| wdata | input | 8 | Write data for index or register |
| rdata | output | 8 | Registered readback of the register at the current index |
| bus_addr | input | 24 | System address to decode |
| hit | output | 1 | Registered: an enabled window matched |
| win_num | output | 3 | Registered: number of the winning window |
| timing_set | output | 1 | Registered: timing set of the winning window |

## Verification
Several properties are checked on every clock cycle:

- The bounds and the enable of a reported window held in the previous cycle.
- No lower-numbered window matched when a higher one was reported.
- The timing set agrees with the winner's selector, and the idle outputs are zero.
- Enable writes land and reset clears the readback.

Other behaviour only the bench scenarios can show. These are the exact inclusive edge pages, a single-page window, overlap between windows, and an inverted window. They also include the register placement, the masked and scratch bits, writes to unused indexes being ignored, and the recovery of every register after a second reset.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int MW_ADDR_W  = 24;
  localparam int MW_PAGE_LG = 12;
  localparam int MW_PG_W    = MW_ADDR_W - MW_PAGE_LG;
  localparam int MW_TSEL_W  = 2;

  typedef struct packed {
    logic                 en;
    logic [MW_TSEL_W-1:0] tsel;
    logic [1:0]           scratch;
    logic [MW_PG_W-1:0]   last_pg;
    logic [MW_PG_W-1:0]   first_pg;
  } win_cfg_t;
endpackage

// File: rtl/memwin_regbank.sv
module memwin_regbank
  import memwin_pkg::*;
#(
  parameter int         NWIN      = 5,
  parameter logic [7:0] BASE_IDX  = 8'h10,
  parameter int         STRIDE_LG = 3,
  parameter logic [7:0] ENA_IDX   = 8'h06
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  idx_wr,
  input  logic                  data_wr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output win_cfg_t [NWIN-1:0]   cfg
);
  localparam int WSEL_W = 8 - STRIDE_LG;

  logic [7:0]           idx_r;
  win_cfg_t [NWIN-1:0]  cfg_r;
  logic [7:0]           rel;
  logic [WSEL_W-1:0]    wsel;
  logic [STRIDE_LG-1:0] off;
  logic                 win_ok;
  logic [7:0]           rd_c;

  always_comb begin
    rel    = idx_r - BASE_IDX;
    wsel   = rel[7:STRIDE_LG];
    off    = rel[STRIDE_LG-1:0];
    win_ok = (idx_r >= BASE_IDX) && (int'(wsel) < NWIN) && (off <= STRIDE_LG'(3));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_r <= '0;
      cfg_r <= '0;
    end else if (idx_wr) begin
      idx_r <= wdata;
    end else if (data_wr) begin
      if (idx_r == ENA_IDX) begin
        for (int w = 0; w < NWIN; w++) cfg_r[w].en <= wdata[w];
      end else begin
        for (int w = 0; w < NWIN; w++) begin
          if (win_ok && int'(wsel) == w) begin
            case (off)
              STRIDE_LG'(0): cfg_r[w].first_pg[7:0]          <= wdata;
              STRIDE_LG'(1): cfg_r[w].first_pg[MW_PG_W-1:8]  <= wdata[3:0];
              STRIDE_LG'(2): cfg_r[w].last_pg[7:0]           <= wdata;
              default: begin
                cfg_r[w].last_pg[MW_PG_W-1:8] <= wdata[3:0];
                cfg_r[w].scratch              <= wdata[5:4];
                cfg_r[w].tsel                 <= wdata[7:6];
              end
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    rd_c = 8'h00;
    if (idx_r == ENA_IDX) begin
      for (int w = 0; w < NWIN; w++) rd_c[w] = cfg_r[w].en;
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (win_ok && int'(wsel) == w) begin
          case (off)
            STRIDE_LG'(0): rd_c = cfg_r[w].first_pg[7:0];
            STRIDE_LG'(1): rd_c = {4'h0, cfg_r[w].first_pg[MW_PG_W-1:8]};
            STRIDE_LG'(2): rd_c = cfg_r[w].last_pg[7:0];
            default:       rd_c = {cfg_r[w].tsel, cfg_r[w].scratch,
                                   cfg_r[w].last_pg[MW_PG_W-1:8]};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_c;
  end

  assign cfg = cfg_r;

  // R1: reset clears the readback
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> rdata == 8'h00);

  // R4: an enable write lands in every window's enable bit
  for (genvar w = 0; w < NWIN; w++) begin : g_ena_chk
    p_enable_write_r4: assert property (@(posedge clk) disable iff (rst)
      (data_wr && !idx_wr && idx_r == ENA_IDX) |=> cfg_r[w].en == $past(wdata[w]));
  end
endmodule

// File: rtl/memwin_match.sv
module memwin_match
  import memwin_pkg::*;
#(
  parameter int NWIN = 5
) (
  input  win_cfg_t [NWIN-1:0]   cfg,
  input  logic [MW_PG_W-1:0]    page,
  output logic [NWIN-1:0]       win_hit
);
  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    logic ordered;
    logic in_lo;
    logic in_hi;
    assign ordered    = cfg[w].first_pg <= cfg[w].last_pg;
    assign in_lo      = page >= cfg[w].first_pg;
    assign in_hi      = page <= cfg[w].last_pg;
    assign win_hit[w] = cfg[w].en && ordered && in_lo && in_hi;
  end
endmodule

// File: rtl/memwin_priority.sv
module memwin_priority #(
  parameter int NWIN   = 5,
  parameter int TSEL_W = 2,
  localparam int NUM_W = $clog2(NWIN)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NWIN-1:0]              win_hit,
  input  logic [NWIN-1:0][TSEL_W-1:0]  tsel,
  output logic                         hit,
  output logic [NUM_W-1:0]             win_num,
  output logic                         timing_set
);
  logic             hit_c;
  logic [NUM_W-1:0] num_c;
  logic             ts_c;

  always_comb begin
    hit_c = 1'b0;
    num_c = '0;
    ts_c  = 1'b0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (win_hit[w]) begin
        hit_c = 1'b1;
        num_c = NUM_W'(w);
        ts_c  = |tsel[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit        <= 1'b0;
      win_num    <= '0;
      timing_set <= 1'b0;
    end else begin
      hit        <= hit_c;
      win_num    <= num_c;
      timing_set <= ts_c;
    end
  end

  // R11: idle outputs are zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (win_num == '0 && !timing_set));
  // R8: a reported window number is in range
  p_num_range_r8: assert property (@(posedge clk) disable iff (rst)
    hit |-> (int'(win_num) < NWIN));
endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter int         NWIN      = 5,
  parameter logic [7:0] BASE_IDX  = 8'h10,
  parameter int         STRIDE_LG = 3,
  parameter logic [7:0] ENA_IDX   = 8'h06,
  localparam int        NUM_W     = $clog2(NWIN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 idx_wr,
  input  logic                 data_wr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [MW_ADDR_W-1:0] bus_addr,
  output logic                 hit,
  output logic [NUM_W-1:0]     win_num,
  output logic                 timing_set
);
  win_cfg_t [NWIN-1:0]             cfg;
  logic [NWIN-1:0]                 win_hit;
  logic [NWIN-1:0][MW_TSEL_W-1:0]  tsel;
  logic [MW_PG_W-1:0]              page;

  assign page = bus_addr[MW_ADDR_W-1:MW_PAGE_LG];

  for (genvar w = 0; w < NWIN; w++) begin : g_tsel
    assign tsel[w] = cfg[w].tsel;
  end

  memwin_regbank #(
    .NWIN(NWIN), .BASE_IDX(BASE_IDX), .STRIDE_LG(STRIDE_LG), .ENA_IDX(ENA_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .data_wr(data_wr),
    .wdata(wdata), .rdata(rdata), .cfg(cfg)
  );

  memwin_match #(.NWIN(NWIN)) u_match (
    .cfg(cfg), .page(page), .win_hit(win_hit)
  );

  memwin_priority #(.NWIN(NWIN), .TSEL_W(MW_TSEL_W)) u_prio (
    .clk(clk), .rst(rst), .win_hit(win_hit), .tsel(tsel),
    .hit(hit), .win_num(win_num), .timing_set(timing_set)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_out_chk
    // R5 R6 R7: a reported window was enabled and bounded the previous page
    p_bounds_held_r5: assert property (@(posedge clk) disable iff (rst)
      (hit && win_num == NUM_W'(w)) |->
        ($past(cfg[w].en) && $past(page) >= $past(cfg[w].first_pg)
         && $past(page) <= $past(cfg[w].last_pg)));
    // R8: no lower-numbered window matched
    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (hit && win_num == NUM_W'(w)) |->
        (($past(win_hit) & NWIN'((1 << w) - 1)) == '0));
    // R9: timing set follows the winner's selector
    p_tset_map_r9: assert property (@(posedge clk) disable iff (rst)
      (hit && win_num == NUM_W'(w)) |-> (timing_set == ($past(cfg[w].tsel) != 2'b00)));
  end
endmodule

// File: tb/tb_memwin_decoder.sv
module tb_memwin_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idx_wr = 1'b0;
  logic        data_wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [23:0] bus_addr = 24'h0;
  logic        hit;
  logic [2:0]  win_num;
  logic        timing_set;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  memwin_decoder dut (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .data_wr(data_wr), .wdata(wdata),
    .rdata(rdata), .bus_addr(bus_addr), .hit(hit), .win_num(win_num),
    .timing_set(timing_set)
  );

  // [31:8] address, [7] hit, [6:4] window, [0] timing set
  localparam int NVEC = 14;
  localparam logic [31:0] VEC [NVEC] = '{
    {24'h0FF_FFF, 8'h00},  // R11 below window 0
    {24'h100_000, 8'h80},  // R5 first page inclusive
    {24'h1FF_FFF, 8'h80},  // R5 last page inclusive
    {24'h180_000, 8'h80},  // R8 overlap, window 0 wins
    {24'h200_000, 8'h91},  // R9 selector 10 -> set 1
    {24'h2FF_FFF, 8'h91},  // R5 window 1 top
    {24'h300_000, 8'h00},  // R11 gap
    {24'h3FF_FFF, 8'h00},  // R11 just below single page
    {24'h400_000, 8'hA1},  // R3 R9 scratch ignored, selector 01
    {24'h400_FFF, 8'hA1},  // R5 single page window
    {24'h401_000, 8'h00},  // R5 just above
    {24'h800_000, 8'h00},  // R7 inverted window
    {24'h7FF_000, 8'h00},  // R7 inverted window
    {24'hA00_000, 8'h00}   // R6 window 4 disabled
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    @(negedge clk); idx_wr = 1'b1; wdata = i;
    @(posedge clk); @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] v);
    set_idx(i);
    data_wr = 1'b1; wdata = v;
    @(posedge clk); @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] i, input logic [7:0] exp);
    set_idx(i);
    @(posedge clk); @(negedge clk);
    chk(tag, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic dec_chk(input string tag, input logic [23:0] a, input logic [7:0] e);
    @(negedge clk); bus_addr = a;
    @(posedge clk); @(negedge clk);
    chk(tag, {27'h0, hit, win_num, timing_set}, {27'h0, e[7], e[6:4], e[0]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset hit/num/ts", {29'h0, hit, win_num[0], timing_set}, 32'h0);
    chk("R1 reset rdata", {24'h0, rdata}, 32'h0);
    rst = 1'b0;

    // window setup
    wr(8'h10, 8'h00); wr(8'h11, 8'h01); wr(8'h12, 8'hFF); wr(8'h13, 8'h01);
    wr(8'h18, 8'h80); wr(8'h19, 8'h01); wr(8'h1A, 8'hFF); wr(8'h1B, 8'h82);
    wr(8'h20, 8'h00); wr(8'h21, 8'hF4); wr(8'h22, 8'h00); wr(8'h23, 8'h74);
    wr(8'h28, 8'h00); wr(8'h29, 8'h08); wr(8'h2A, 8'hFF); wr(8'h2B, 8'h07);
    wr(8'h30, 8'h00); wr(8'h31, 8'h0A); wr(8'h32, 8'hFF); wr(8'h33, 8'hCF);
    wr(8'h06, 8'h0F);

    rd_chk("R2 first low w1", 8'h18, 8'h80);
    rd_chk("R2 first high w2 masks 7:4", 8'h21, 8'h04);
    rd_chk("R2 last low w0", 8'h12, 8'hFF);
    rd_chk("R3 end high w2 scratch+tsel", 8'h23, 8'h74);
    rd_chk("R3 end high w4", 8'h33, 8'hCF);
    rd_chk("R4 enable reg", 8'h06, 8'h0F);

    for (int k = 0; k < NVEC; k++) begin
      dec_chk($sformatf("R5 vector %0d", k), VEC[k][31:8], VEC[k][7:0]);
    end

    // R4 upper bits read zero; R6 enabling window 4
    wr(8'h06, 8'hFF);
    rd_chk("R4 enable upper bits zero", 8'h06, 8'h1F);
    dec_chk("R6 window 4 enabled", 24'hA00_000, 8'hC1);
    dec_chk("R5 window 4 top", 24'hFFF_FFF, 8'hC1);

    // R6 disabling window 0 exposes window 1
    wr(8'h06, 8'h1E);
    dec_chk("R6 w0 disabled overlap -> w1", 24'h180_000, 8'h91);
    dec_chk("R6 w0 disabled miss", 24'h100_000, 8'h00);

    // R7 inverted window made ordered then hits
    wr(8'h2A, 8'h00); wr(8'h2B, 8'h08);
    dec_chk("R7 window 3 now single page", 24'h800_000, 8'hB0);

    // R10 unused indexes
    wr(8'h14, 8'h5A);
    rd_chk("R10 unused 14h reads zero", 8'h14, 8'h00);
    wr(8'h08, 8'hA5);
    rd_chk("R10 unused 08h reads zero", 8'h08, 8'h00);
    wr(8'h38, 8'h33);
    rd_chk("R10 unused 38h reads zero", 8'h38, 8'h00);
    wr(8'h00, 8'h77);
    rd_chk("R10 unused 00h reads zero", 8'h00, 8'h00);
    rd_chk("R10 w0 end high untouched", 8'h13, 8'h01);
    rd_chk("R10 w1 first low untouched", 8'h18, 8'h80);
    rd_chk("R10 enable untouched", 8'h06, 8'h1E);

    // R3 scratch change has no decode effect
    wr(8'h23, 8'h44);
    rd_chk("R3 scratch cleared", 8'h23, 8'h44);
    dec_chk("R3 decode unchanged", 24'h400_800, 8'hA1);

    // R1 second reset
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    chk("R1 reset clears hit", {31'h0, hit}, 32'h0);
    rd_chk("R1 end high cleared", 8'h13, 8'h00);
    rd_chk("R1 first low cleared", 8'h18, 8'h00);
    rd_chk("R1 enable cleared", 8'h06, 8'h00);
    dec_chk("R1 R11 no hit after reset", 24'h000_000, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule